// File: doc/BRIEF.md
# Strap-Configurable Interrupt Message Collector

This block gathers active-high, level-sensitive interrupt lines and converts each pending line into a single memory-write message. The message goes out on a valid/ready port as an address/data pair. No acknowledge cycle runs: the message carries everything the receiver needs. Each line has a routing entry made up of an 8-bit vector, a 4-bit priority and a mask bit. A line's priority is set in its entry and has nothing to do with the line's number.

The number of lines in use depends on a strap sampled when power-good rises. With the strap clear, 24 base lines are active. With it set, 16 extended lines are added, for 40 in total. A per-pin use-select input can return each extended pin to general-purpose use, and the pin then cannot interrupt. A register port shows the maximum-entry index for the latched strap. The same port holds the routing entries and accepts end-of-interrupt writes. Each line has an in-service flag, so a line that is still asserted after its end-of-interrupt write raises a new message.

Top module: `irq_aggregator`

## Requirements
- R1: The strap value is latched only on a rising edge of `pwr_good`; reset clears it, and changing `strap_ext` at any other time has no effect.
- R2: Register address 0x00 reads version 0x20 in bits [7:0] and the maximum-entry index in bits [23:16]: 0x17 while the latched strap is clear, 0x27 while it is set.
- R3: While the latched strap is clear, lines 24 to 39 never produce a message, whatever `gpio_sel` holds.
- R4: While the latched strap is set, extended line 24+k can produce messages only when `gpio_sel[k]` is 0 (interrupt mode); with `gpio_sel[k]` at 1 (general-purpose mode) it produces none.
- R5: Entry n is at address 0x40+n, with vector in bits [7:0], priority in [11:8] and mask in [16]; it reads back as written, and after reset every entry reads 0x00010000 (masked).
- R6: A line whose entry mask bit is 1 produces no message.
- R7: Among eligible lines the one with the numerically highest priority is sent first; on equal priority the lowest line index wins.
- R8: A message appears one cycle after its line becomes eligible, with `msg_addr` = 0xFEE00000 and `msg_data` = {16'h0, line index[7:0], vector[7:0]}; `msg_valid` is 0 after reset.
- R9: Only one message is outstanding at a time: while `msg_valid` is 1 and `msg_ready` is 0, the message stays valid and unchanged.
- R10: A sent line is in service and is not sent again until a write of its index to address 0x01 (end of interrupt). After that write it is sent again only if the line is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; the strap is sampled on its rising edge |
| strap_ext | input | 1 | Strap selecting the extended line count |
| irq_in | input | 40 | Active-high level interrupt lines |
| gpio_sel | input | 16 | Per extended pin: 1 = general-purpose, 0 = interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by receiver |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the block with its default line counts of 24 base and 16 extended lines. With these values both strap settings can be reached within one run: the bench lowers and raises power-good again to switch them. It can then reach line 39, the top edge of the extended range, and two lines with equal priority where the higher index carries the larger vector. Holding ready low brings the single-outstanding rule and the priority order within reach, together with re-sending after an end-of-interrupt write.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int          BASE_LINES = 24,
  parameter int          EXT_LINES  = 16,
  parameter int          PRIO_W     = 4,
  parameter logic [7:0]  VERSION    = 8'h20,
  parameter logic [31:0] MSG_BASE   = 32'hFEE0_0000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pwr_good,
  input  logic                            strap_ext,
  input  logic [BASE_LINES+EXT_LINES-1:0] irq_in,
  input  logic [EXT_LINES-1:0]            gpio_sel,
  input  logic                            reg_wr,
  input  logic [7:0]                      reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic                            msg_valid,
  input  logic                            msg_ready,
  output logic [31:0]                     msg_addr,
  output logic [31:0]                     msg_data
);
  localparam int TOTAL = BASE_LINES + EXT_LINES;
  localparam int IW    = $clog2(TOTAL);
  localparam logic [7:0] MAX_BASE = 8'(BASE_LINES - 1);
  localparam logic [7:0] MAX_EXT  = 8'(TOTAL - 1);

  logic              pg_q, strap_q;
  logic [7:0]        vec_q  [TOTAL];
  logic [PRIO_W-1:0] prio_q [TOTAL];
  logic [TOTAL-1:0]  mask_q, insvc_q, line_en, eligible;
  logic [7:0]        msg_vec_q;
  logic [IW-1:0]     msg_idx_q;

  // Strap capture on power-good rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q    <= 1'b0;
      strap_q <= 1'b0;
    end else begin
      pg_q <= pwr_good;
      if (pwr_good && !pg_q) strap_q <= strap_ext;
    end
  end

  // Line enables
  genvar g;
  generate
    for (g = 0; g < TOTAL; g++) begin : g_en
      if (g < BASE_LINES) begin : g_base
        assign line_en[g] = 1'b1;
      end else begin : g_ext
        assign line_en[g] = strap_q & ~gpio_sel[g - BASE_LINES];
      end
    end
  endgenerate

  assign eligible = irq_in & line_en & ~mask_q & ~insvc_q;

  // Register decode
  wire entry_hit = (reg_addr[7:6] == 2'b01) && (32'(reg_addr[5:0]) < TOTAL);
  wire eoi_hit   = reg_wr && (reg_addr == 8'h01) && (32'(reg_wdata[7:0]) < TOTAL);
  wire [IW-1:0] entry_idx = reg_addr[IW-1:0];
  wire [IW-1:0] eoi_idx   = reg_wdata[IW-1:0];
  wire unused_wdata = ^{reg_wdata[31:17], reg_wdata[15:12]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int i = 0; i < TOTAL; i++) begin
        vec_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else if (reg_wr && entry_hit) begin
      vec_q[entry_idx]  <= reg_wdata[7:0];
      prio_q[entry_idx] <= reg_wdata[8 +: PRIO_W];
      mask_q[entry_idx] <= reg_wdata[16];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 8'h00)
      reg_rdata = {8'h0, strap_q ? MAX_EXT : MAX_BASE, 8'h0, VERSION};
    else if (entry_hit)
      reg_rdata = {15'h0, mask_q[entry_idx], 4'h0,
                   {(4-PRIO_W){1'b0}}, prio_q[entry_idx], vec_q[entry_idx]};
  end

  // Priority pick: highest value, lowest index on ties
  logic              found;
  logic [IW-1:0]     best_idx;
  logic [PRIO_W-1:0] best_p;
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_p   = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (eligible[i] && (!found || prio_q[i] > best_p)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_p   = prio_q[i];
      end
    end
  end

  wire issue = found && !msg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_q <= '0;
    end else begin
      if (eoi_hit) insvc_q[eoi_idx] <= 1'b0;
      if (issue)   insvc_q[best_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_vec_q <= '0;
      msg_idx_q <= '0;
    end else if (issue) begin
      msg_valid <= 1'b1;
      msg_vec_q <= vec_q[best_idx];
      msg_idx_q <= best_idx;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assign msg_addr = MSG_BASE;
  assign msg_data = {16'h0, 8'(msg_idx_q), msg_vec_q};

  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_good && !pg_q) |=> $stable(strap_q));

  assert_upper_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && 32'(msg_idx_q) >= BASE_LINES) |-> $past(strap_q));

  assert_gpio_mode_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && 32'(msg_idx_q) >= BASE_LINES) |->
      ((($past(gpio_sel) >> (32'(msg_idx_q) - BASE_LINES)) & EXT_LINES'(1)) == '0));

  assert_hold_until_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data)));

  assert_in_service_on_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> insvc_q[msg_idx_q]);
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic        clk = 0, rst_n = 0, pwr_good = 0, strap_ext = 0;
  logic [39:0] irq_in = '0;
  logic [15:0] gpio_sel = '0;
  logic        reg_wr = 0, msg_ready = 0, msg_valid;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, msg_addr, msg_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_ext(strap_ext),
    .irq_in(irq_in), .gpio_sel(gpio_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
    reg_addr = 8'h00;
  endtask

  task automatic entry(input int n, input bit m, input logic [3:0] p, input logic [7:0] v);
    wr(8'h40 + 8'(n), {15'h0, m, 4'h0, p, v});
  endtask

  task automatic expect_msg(input int idx, input logic [7:0] v, input string tag);
    logic [31:0] exp = {16'h0, 8'(idx), v};
    @(posedge clk); @(negedge clk);
    chk(msg_valid === 1'b1, tag, {31'h0, msg_valid}, 32'h1);
    chk(msg_data === exp, tag, msg_data, exp);
  endtask

  task automatic deliver;
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  task automatic expect_none(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(msg_valid === 1'b0, tag, {31'h0, msg_valid}, 32'h0);
    end
  endtask

  task automatic power_up(input bit s);
    @(negedge clk); pwr_good = 0; strap_ext = s;
    @(negedge clk); pwr_good = 1;
    @(negedge clk); strap_ext = ~s;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(msg_valid === 1'b0, "R8 reset valid", {31'h0, msg_valid}, 32'h0);
    rd(8'h00, 32'h0017_0020, "R2 version after reset");
    rd(8'h45, 32'h0001_0000, "R5 entry reset masked");
  endtask

  task automatic t_strap_clear;
    power_up(0);
    rd(8'h00, 32'h0017_0020, "R1 strap clear latched, later change ignored");
    entry(30, 0, 4'h3, 8'h55);
    entry(39, 0, 4'h1, 8'h99);
    @(negedge clk); irq_in[30] = 1; irq_in[39] = 1;
    expect_none(4, "R3 extended lines silent with strap clear");
    @(negedge clk); irq_in[30] = 0; irq_in[39] = 0;
  endtask

  task automatic t_priority;
    entry(3, 0, 4'h2, 8'h33);
    entry(10, 0, 4'h9, 8'hA0);
    entry(5, 0, 4'h9, 8'h50);
    entry(7, 1, 4'hF, 8'h77);
    rd(8'h45, 32'h0000_0950, "R5 entry readback");
    rd(8'h47, 32'h0001_0F77, "R5 masked entry readback");
    @(negedge clk); irq_in[3] = 1; irq_in[10] = 1; irq_in[5] = 1; irq_in[7] = 1;
    expect_msg(5, 8'h50, "R7 tie goes to lower index");
    chk(msg_addr === 32'hFEE0_0000, "R8 message address", msg_addr, 32'hFEE0_0000);
    repeat (3) @(negedge clk);
    chk(msg_valid === 1'b1 && msg_data === 32'h0000_0550, "R9 held while not ready",
        msg_data, 32'h0000_0550);
    deliver;
    expect_msg(10, 8'hA0, "R7 next highest priority");
    deliver;
    expect_msg(3, 8'h33, "R7 low priority line last");
    deliver;
    expect_none(3, "R6 masked line silent and R10 no repeat while in service");
    wr(8'h01, 32'd10);
    expect_msg(10, 8'hA0, "R10 resend after EOI while asserted");
    deliver;
    @(negedge clk); irq_in[5] = 0;
    wr(8'h01, 32'd5);
    expect_none(3, "R10 no resend after EOI when released");
    @(negedge clk); irq_in = '0;
    wr(8'h01, 32'd3);
    wr(8'h01, 32'd10);
  endtask

  task automatic t_strap_set;
    power_up(1);
    rd(8'h00, 32'h0027_0020, "R2 max entry with strap set");
    @(negedge clk); irq_in[30] = 1;
    expect_msg(30, 8'h55, "R4 extended line in interrupt mode");
    deliver;
    @(negedge clk); irq_in[30] = 0;
    wr(8'h01, 32'd30);
    @(negedge clk); irq_in[39] = 1;
    expect_msg(39, 8'h99, "R4 top extended line");
    deliver;
    @(negedge clk); irq_in[39] = 0;
    wr(8'h01, 32'd39);
    @(negedge clk); gpio_sel[6] = 1; irq_in[30] = 1;
    expect_none(4, "R4 general-purpose pin silent");
    @(negedge clk); irq_in[30] = 0; gpio_sel = '0;
  endtask

  initial begin
    t_reset;
    t_strap_clear;
    t_priority;
    t_strap_set;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule